// File: doc/BRIEF.md
# SMBus configuration register slave with chip select

This block is the configuration port of a larger device. It listens on a two-wire bus of clock (SCL) and data (SDA) lines, oversampled by the system clock behind a synchronizer. It answers only while an active-high chip-select input is high. On SDA the slave can only pull the line low. That open-drain drive appears as an output enable: when `sda_oe` is high the pad pulls SDA to 0. The bench models the wired-AND of master and slave.

The slave finds START and STOP conditions and clocks in bytes MSB first. It acknowledges its own address and the bytes written to it. It returns register bytes on read cycles. An auto-incrementing byte pointer selects the register. The layout is as follows. Address 0x00 holds the device's own 7-bit bus address and can be rewritten. Address 0x01 is a write-only control byte; bit 0 is the soft-reset trigger. Address 0x02 shows the read-only `status_in` byte. Addresses 0x03 onward are `NCFG` writable configuration bytes that leave the block on `cfg_o`.

Top module: `smb_cfg_slave`

## Requirements
- R1: A START (SDA falling while SCL is high) restarts address reception from any state, including part way through a byte. A STOP (SDA rising while SCL is high) returns the slave to idle.
- R2: Bytes are sampled on SCL rising edges, MSB first. To acknowledge, the slave pulls SDA low (0 = ACK) for the ninth clock and releases it after that clock's falling edge.
- R3: A write consists of the address byte with bit 0 = 0, then a pointer byte, then data bytes. Each data byte is stored at the pointer, and the pointer then advances by one.
- R4: A read consists of address and pointer bytes, a repeated START, then the address byte with bit 0 = 1. The slave then sends the register at the pointer, MSB first. Each master ACK (0) advances the pointer and starts the next byte. A master NACK (1) ends the read with SDA released.
- R5: Register 0x00 holds the device address in bits 7:1, resets to 0x58, and reads back with bit 0 = 0. A new value written there is the address matched from the next address byte onward.
- R6: Writing a byte with bit 0 = 1 to 0x01 restores every configuration byte to its default, 0x30 + i for byte i. Register 0x00 is left unchanged. Register 0x01 reads as 0x00.
- R7: While chip select is low, the slave never drives SDA, acknowledges nothing, and changes no register.
- R8: If the address byte does not match, the slave does not acknowledge it. It then ignores the bus until the next START or STOP.
- R9: Register 0x02 reads the `status_in` input. Writes to it are acknowledged and have no effect.
- R10: Addresses above 0x02 + NCFG read as 0x00. Writes to them are acknowledged and have no effect.
- R11: The slave begins to pull SDA low only while SCL is low.
- R12: After reset the slave does not drive SDA, and `cfg_o` holds the defaults 0x30 + i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs | input | 1 | Chip select, high enables the bus slave |
| scl_in | input | 1 | Bus clock as seen on the wire |
| sda_in | input | 1 | Bus data as seen on the wire |
| sda_oe | output | 1 | High pulls SDA low (open-drain drive) |
| status_in | input | 8 | Byte presented at read-only register 0x02 |
| cfg_o | output | NCFG*8 | Configuration bytes, byte i at bits 8i+7:8i |

## Verification
Two situations are hard to reach from the ports. One is a bus event in mid-frame: a START that cuts a byte short, or an address rewrite that takes effect inside an open write. The other is a soft reset that must spare the address register it sits next to. The bench drives these with directed bit-level sequences. It aborts a byte after four bits, rewrites register 0x00 and then switches to the new address, and fires the control bit after loading non-default configuration. Chip select is dropped around a full write with a matching address. Random bursts of writes and repeated-START reads over the whole map, unmapped bytes included, then exercise pointer wrap-through and the read-only bytes against a bench model.

// File: rtl/smb_pkg.sv
package smb_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV,
        ST_DEV_ACK,
        ST_PTR,
        ST_PTR_ACK,
        ST_WR,
        ST_WR_ACK,
        ST_RD,
        ST_RD_ACK,
        ST_SKIP
    } smb_state_e;

    typedef struct packed {
        smb_state_e  st;
        logic [7:0]  sh;
        logic [3:0]  cnt;
        logic [7:0]  ptr;
        logic        oe;
        logic        rd_mode;
        logic        go_on;
        logic        scl_p;
        logic        sda_p;
    } smb_ctx_t;

    function automatic logic [7:0] cfg_default(int idx);
        return 8'h30 + 8'(idx);
    endfunction

endpackage

// File: rtl/smb_sync.sv
module smb_sync #(
    parameter int           W       = 3,
    parameter int           STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg_q[i] <= RST_VAL;
        end else begin
            stg_q[0] <= d;
            for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
        end
    end

    assign q = stg_q[STAGES-1];
endmodule

// File: rtl/smb_regfile.sv
module smb_regfile
    import smb_pkg::*;
#(
    parameter int         NCFG     = 4,
    parameter logic [6:0] ADDR_RST = 7'h58
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [7:0]      wr_addr,
    input  logic [7:0]      wr_data,
    input  logic [7:0]      rd_addr,
    input  logic [7:0]      status_in,
    output logic [7:0]      rd_data,
    output logic [6:0]      dev_addr,
    output logic [NCFG*8-1:0] cfg_o
);
    localparam logic [7:0] A_DEV    = 8'h00;
    localparam logic [7:0] A_CTRL   = 8'h01;
    localparam logic [7:0] A_STAT   = 8'h02;
    localparam int         CFG_BASE = 3;

    logic [6:0] dev_d, dev_q;
    logic [7:0] cfg_d [NCFG];
    logic [7:0] cfg_q [NCFG];

    always_comb begin
        dev_d = dev_q;
        cfg_d = cfg_q;
        if (wr_en) begin
            if (wr_addr == A_DEV) begin
                dev_d = wr_data[7:1];
            end else if (wr_addr == A_CTRL) begin
                if (wr_data[0]) begin
                    for (int i = 0; i < NCFG; i++) cfg_d[i] = cfg_default(i);
                end
            end else begin
                for (int i = 0; i < NCFG; i++) begin
                    if (wr_addr == 8'(CFG_BASE + i)) cfg_d[i] = wr_data;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dev_q <= ADDR_RST;
            for (int i = 0; i < NCFG; i++) cfg_q[i] <= cfg_default(i);
        end else begin
            dev_q <= dev_d;
            cfg_q <= cfg_d;
        end
    end

    always_comb begin
        rd_data = 8'h00;
        if (rd_addr == A_DEV)  rd_data = {dev_q, 1'b0};
        if (rd_addr == A_STAT) rd_data = status_in;
        for (int i = 0; i < NCFG; i++) begin
            if (rd_addr == 8'(CFG_BASE + i)) rd_data = cfg_q[i];
        end
    end

    assign dev_addr = dev_q;

    for (genvar g = 0; g < NCFG; g++) begin : g_pack
        assign cfg_o[g*8 +: 8] = cfg_q[g];
    end
endmodule

// File: rtl/smb_cfg_slave.sv
module smb_cfg_slave
    import smb_pkg::*;
#(
    parameter int         NCFG        = 4,
    parameter logic [6:0] ADDR_RST    = 7'h58,
    parameter int         SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              sda_oe,
    input  logic [7:0]        status_in,
    output logic [NCFG*8-1:0] cfg_o
);
    localparam logic [3:0] BITS = 4'd8;

    logic [2:0] pins_s;
    logic       scl_s, sda_s, cs_s;
    logic       ev_start, ev_stop, ev_rise, ev_fall;
    logic       wr_en;
    logic [7:0] wr_addr, wr_data, rd_data;
    logic [6:0] dev_addr;
    smb_ctx_t   c_d, c_q;

    smb_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b011)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    ({cs, sda_in, scl_in}),
        .q    (pins_s)
    );
    assign {cs_s, sda_s, scl_s} = pins_s;

    assign ev_start = scl_s &  c_q.scl_p &  c_q.sda_p & ~sda_s;
    assign ev_stop  = scl_s &  c_q.scl_p & ~c_q.sda_p &  sda_s;
    assign ev_rise  = scl_s & ~c_q.scl_p;
    assign ev_fall  = ~scl_s & c_q.scl_p;

    always_comb begin
        c_d       = c_q;
        c_d.scl_p = scl_s;
        c_d.sda_p = sda_s;
        wr_en     = 1'b0;
        wr_addr   = c_q.ptr;
        wr_data   = c_q.sh;
        if (!cs_s) begin
            c_d.st  = ST_IDLE;
            c_d.oe  = 1'b0;
            c_d.cnt = '0;
        end else if (ev_start) begin
            c_d.st  = ST_DEV;
            c_d.oe  = 1'b0;
            c_d.cnt = '0;
        end else if (ev_stop) begin
            c_d.st  = ST_IDLE;
            c_d.oe  = 1'b0;
        end else begin
            case (c_q.st)
                ST_DEV, ST_PTR, ST_WR: begin
                    if (ev_rise) begin
                        c_d.sh  = {c_q.sh[6:0], sda_s};
                        c_d.cnt = c_q.cnt + 4'd1;
                    end else if (ev_fall && c_q.cnt == BITS) begin
                        c_d.cnt = '0;
                        if (c_q.st == ST_DEV) begin
                            if (c_q.sh[7:1] == dev_addr) begin
                                c_d.oe      = 1'b1;
                                c_d.rd_mode = c_q.sh[0];
                                c_d.st      = ST_DEV_ACK;
                            end else begin
                                c_d.st = ST_SKIP;
                            end
                        end else if (c_q.st == ST_PTR) begin
                            c_d.ptr = c_q.sh;
                            c_d.oe  = 1'b1;
                            c_d.st  = ST_PTR_ACK;
                        end else begin
                            wr_en   = 1'b1;
                            c_d.ptr = c_q.ptr + 8'd1;
                            c_d.oe  = 1'b1;
                            c_d.st  = ST_WR_ACK;
                        end
                    end
                end
                ST_DEV_ACK: begin
                    if (ev_fall) begin
                        if (c_q.rd_mode) begin
                            c_d.sh  = rd_data;
                            c_d.oe  = ~rd_data[7];
                            c_d.cnt = '0;
                            c_d.st  = ST_RD;
                        end else begin
                            c_d.oe = 1'b0;
                            c_d.st = ST_PTR;
                        end
                    end
                end
                ST_PTR_ACK, ST_WR_ACK: begin
                    if (ev_fall) begin
                        c_d.oe = 1'b0;
                        c_d.st = ST_WR;
                    end
                end
                ST_RD: begin
                    if (ev_rise) begin
                        c_d.cnt = c_q.cnt + 4'd1;
                    end else if (ev_fall) begin
                        if (c_q.cnt == BITS) begin
                            c_d.oe = 1'b0;
                            c_d.st = ST_RD_ACK;
                        end else begin
                            c_d.sh = {c_q.sh[6:0], 1'b0};
                            c_d.oe = ~c_q.sh[6];
                        end
                    end
                end
                ST_RD_ACK: begin
                    if (ev_rise) begin
                        c_d.go_on = ~sda_s;
                        if (!sda_s) c_d.ptr = c_q.ptr + 8'd1;
                    end else if (ev_fall) begin
                        if (c_q.go_on) begin
                            c_d.sh  = rd_data;
                            c_d.oe  = ~rd_data[7];
                            c_d.cnt = '0;
                            c_d.st  = ST_RD;
                        end else begin
                            c_d.st = ST_SKIP;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q       <= '0;
            c_q.st    <= ST_IDLE;
            c_q.scl_p <= 1'b1;
            c_q.sda_p <= 1'b1;
        end else begin
            c_q <= c_d;
        end
    end

    assign sda_oe = c_q.oe;

    smb_regfile #(.NCFG(NCFG), .ADDR_RST(ADDR_RST)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_addr  (c_q.ptr),
        .status_in(status_in),
        .rd_data  (rd_data),
        .dev_addr (dev_addr),
        .cfg_o    (cfg_o)
    );
endmodule

// File: rtl/smb_cfg_slave_chk.sv
module smb_cfg_slave_chk
    import smb_pkg::*;
#(
    parameter int NCFG = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs,
    input logic              sda_oe,
    input logic              scl_s,
    input logic              wr_en,
    input logic [7:0]        wr_addr,
    input logic [7:0]        wr_data,
    input logic [6:0]        dev_addr,
    input logic [NCFG*8-1:0] cfg_o
);
    function automatic logic [NCFG*8-1:0] all_defaults();
        logic [NCFG*8-1:0] v;
        for (int i = 0; i < NCFG; i++) v[i*8 +: 8] = cfg_default(i);
        return v;
    endfunction

    logic [1:0] cs_lo_cnt;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                cs_lo_cnt <= '0;
        else if (cs)               cs_lo_cnt <= '0;
        else if (cs_lo_cnt != 2'd3) cs_lo_cnt <= cs_lo_cnt + 2'd1;
    end

    a_r7_cs_low_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_lo_cnt == 2'd3) |-> !sda_oe);

    a_r11_drive_onset_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_s);

    a_r6_soft_reset_defaults: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 8'h01 && wr_data[0]) |=> (cfg_o == all_defaults()) && $stable(dev_addr));

    a_r5_addr_only_by_write: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_addr == 8'h00) |=> $stable(dev_addr));

    a_r9_cfg_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(cfg_o));
endmodule

bind smb_cfg_slave smb_cfg_slave_chk #(.NCFG(NCFG)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cs      (cs),
    .sda_oe  (sda_oe),
    .scl_s   (scl_s),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .dev_addr(dev_addr),
    .cfg_o   (cfg_o)
);

// File: tb/smb_cfg_slave_bench.sv
module smb_cfg_slave_bench;
    localparam int NCFG = 4;
    localparam int Q    = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs = 1'b1;
    logic scl = 1'b1;
    logic sda_m = 1'b1;
    logic [7:0] status_in = 8'h5A;
    logic sda_oe;
    logic [NCFG*8-1:0] cfg_o;
    logic sda_bus;

    int n_chk = 0;
    int n_bad = 0;
    int cs_viol = 0;
    int onset_viol = 0;
    int cs_lo_cycles = 0;
    logic oe_prev = 1'b0;

    logic [6:0] m_dev;
    logic [7:0] m_cfg [NCFG];
    logic [7:0] wbuf [8];
    logic [7:0] rbuf [8];

    always #5 clk = ~clk;
    assign sda_bus = sda_m & ~sda_oe;

    smb_cfg_slave u_smb_cfg_slave (
        .clk(clk), .rst_n(rst_n), .cs(cs), .scl_in(scl), .sda_in(sda_bus),
        .sda_oe(sda_oe), .status_in(status_in), .cfg_o(cfg_o)
    );

    always @(negedge clk) begin
        cs_lo_cycles = cs ? 0 : cs_lo_cycles + 1;
        if (cs_lo_cycles > 4 && sda_oe) cs_viol++;
        if (sda_oe && !oe_prev && scl) onset_viol++;
        oe_prev = sda_oe;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: act=timeout exp=finish");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [7:0] def_cfg(int i);
        return 8'h30 + 8'(i);
    endfunction

    function automatic logic [7:0] exp_reg(logic [7:0] a);
        if (a == 8'h00) return {m_dev, 1'b0};
        if (a == 8'h02) return status_in;
        if (a >= 8'h03 && a < 8'(3 + NCFG)) return m_cfg[a - 8'h03];
        return 8'h00;
    endfunction

    function automatic logic [NCFG*8-1:0] exp_cfg_flat();
        logic [NCFG*8-1:0] v;
        for (int i = 0; i < NCFG; i++) v[i*8 +: 8] = m_cfg[i];
        return v;
    endfunction

    task automatic model_write(input logic [7:0] a, input logic [7:0] d);
        if (a == 8'h00) m_dev = d[7:1];
        else if (a == 8'h01) begin
            if (d[0]) for (int i = 0; i < NCFG; i++) m_cfg[i] = def_cfg(i);
        end else if (a >= 8'h03 && a < 8'(3 + NCFG)) m_cfg[a - 8'h03] = d;
    endtask

    task automatic bus_start();
        sda_m = 1'b1; tick(Q);
        scl = 1'b1;   tick(Q);
        sda_m = 1'b0; tick(Q);
        scl = 1'b0;   tick(2);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(Q);
        scl = 1'b1;   tick(Q);
        sda_m = 1'b1; tick(Q);
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            sda_m = b[i]; tick(Q);
            scl = 1'b1;   tick(2 * Q);
            scl = 1'b0;   tick(2);
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        send_bits(b, 8);
        sda_m = 1'b1; tick(Q);
        scl = 1'b1;   tick(Q);
        ack = ~sda_bus;
        tick(Q);
        scl = 1'b0;   tick(2);
    endtask

    task automatic recv_byte(input logic mack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            tick(Q);
            scl = 1'b1; tick(Q);
            b[i] = sda_bus;
            tick(Q);
            scl = 1'b0; tick(2);
        end
        sda_m = mack; tick(Q);
        scl = 1'b1;   tick(2 * Q);
        scl = 1'b0;   tick(2);
        sda_m = 1'b1;
    endtask

    task automatic do_write(input logic [6:0] dev, input logic [7:0] a, input int n, output int acks);
        logic ack;
        acks = 0;
        bus_start();
        send_byte({dev, 1'b0}, ack); acks += int'(ack);
        send_byte(a, ack);           acks += int'(ack);
        for (int k = 0; k < n; k++) begin
            send_byte(wbuf[k], ack); acks += int'(ack);
        end
        bus_stop();
    endtask

    task automatic do_read(input logic [6:0] dev, input logic [7:0] a, input int n, output int acks);
        logic ack;
        logic [7:0] b;
        acks = 0;
        bus_start();
        send_byte({dev, 1'b0}, ack); acks += int'(ack);
        send_byte(a, ack);           acks += int'(ack);
        bus_start();
        send_byte({dev, 1'b1}, ack); acks += int'(ack);
        for (int k = 0; k < n; k++) begin
            recv_byte((k == n - 1), b);
            rbuf[k] = b;
        end
        bus_stop();
    endtask

    initial begin
        int acks;
        logic ack;
        logic [NCFG*8-1:0] snap;
        void'($urandom(32'd4711));
        m_dev = 7'h58;
        for (int i = 0; i < NCFG; i++) m_cfg[i] = def_cfg(i);
        tick(5);
        rst_n = 1'b1;
        tick(5);

        // R12 reset state
        check("R12 oe after reset", 32'(sda_oe), 32'd0);
        check("R12 cfg after reset", 32'(cfg_o), 32'(exp_cfg_flat()));

        // R5 R6 R9 R4: burst read from 0x00
        do_read(m_dev, 8'h00, 3, acks);
        check("R4 read acks", acks, 3);
        check("R5 reg0 reset value", 32'(rbuf[0]), 32'h0000_00B0);
        check("R6 ctrl reads zero", 32'(rbuf[1]), 32'd0);
        check("R9 status read", 32'(rbuf[2]), 32'(status_in));

        // R3 R2 multi-byte write then readback
        for (int k = 0; k < NCFG; k++) wbuf[k] = 8'hC0 + 8'(k * 17);
        do_write(m_dev, 8'h03, NCFG, acks);
        for (int k = 0; k < NCFG; k++) model_write(8'(3 + k), wbuf[k]);
        check("R2 write acks", acks, NCFG + 2);
        check("R3 cfg after burst write", 32'(cfg_o), 32'(exp_cfg_flat()));
        do_read(m_dev, 8'h03, NCFG, acks);
        for (int k = 0; k < NCFG; k++) check("R4 burst readback", 32'(rbuf[k]), 32'(exp_reg(8'(3 + k))));

        // R9 R10 read-only and unmapped writes
        wbuf[0] = 8'hFF;
        do_write(m_dev, 8'h02, 1, acks);
        check("R9 ro write acked", acks, 3);
        do_write(m_dev, 8'h20, 1, acks);
        check("R10 unmapped write acked", acks, 3);
        do_read(m_dev, 8'h02, 1, acks);
        check("R9 ro unchanged", 32'(rbuf[0]), 32'(status_in));
        do_read(m_dev, 8'h20, 1, acks);
        check("R10 unmapped reads zero", 32'(rbuf[0]), 32'd0);
        check("R10 cfg untouched", 32'(cfg_o), 32'(exp_cfg_flat()));

        // R8 mismatched address
        snap = cfg_o;
        bus_start();
        send_byte({7'h22, 1'b0}, ack);
        check("R8 mismatch nack", 32'(ack), 32'd0);
        send_byte(8'h03, ack);
        check("R8 ignored pointer", 32'(ack), 32'd0);
        send_byte(8'h99, ack);
        bus_stop();
        check("R8 cfg unchanged", 32'(cfg_o), 32'(snap));

        // R7 chip select low
        cs = 1'b0; tick(10);
        wbuf[0] = 8'h77;
        do_write(m_dev, 8'h03, 1, acks);
        check("R7 no ack with cs low", acks, 0);
        cs = 1'b1; tick(10);
        check("R7 cfg unchanged", 32'(cfg_o), 32'(exp_cfg_flat()));
        check("R7 sda never driven", cs_viol, 0);

        // R1 START part way through a byte
        bus_start();
        send_bits(8'hB0, 4);
        wbuf[0] = 8'h3C;
        do_write(m_dev, 8'h04, 1, acks);
        model_write(8'h04, 8'h3C);
        check("R1 restart acks", acks, 3);
        check("R1 cfg after restart", 32'(cfg_o), 32'(exp_cfg_flat()));

        // R5 new device address
        wbuf[0] = 8'h42;
        do_write(m_dev, 8'h00, 1, acks);
        model_write(8'h00, 8'h42);
        do_read(7'h58, 8'h00, 1, acks);
        check("R5 old address nacked", acks, 0);
        do_read(7'h21, 8'h00, 1, acks);
        check("R5 new address acked", acks, 3);
        check("R5 reg0 value", 32'(rbuf[0]), 32'h42);

        // R6 soft reset keeps reg0
        wbuf[0] = 8'h01;
        do_write(m_dev, 8'h01, 1, acks);
        model_write(8'h01, 8'h01);
        check("R6 cfg defaults", 32'(cfg_o), 32'(exp_cfg_flat()));
        do_read(m_dev, 8'h00, 1, acks);
        check("R6 reg0 kept", 32'(rbuf[0]), 32'h42);

        // random mix
        for (int it = 0; it < 30; it++) begin
            logic [7:0] a;
            int n;
            a = 8'(1 + ($urandom % 8));
            n = 1 + int'($urandom % 3);
            status_in = 8'($urandom);
            if ($urandom % 2 == 0) begin
                for (int k = 0; k < n; k++) wbuf[k] = 8'($urandom);
                do_write(m_dev, a, n, acks);
                for (int k = 0; k < n; k++) model_write(8'(a + k), wbuf[k]);
                check("R3 random write acks", acks, n + 2);
                check("R3 random cfg", 32'(cfg_o), 32'(exp_cfg_flat()));
            end else begin
                do_read(m_dev, a, n, acks);
                check("R4 random read acks", acks, 3);
                for (int k = 0; k < n; k++) check("R4 random read data", 32'(rbuf[k]), 32'(exp_reg(8'(a + k))));
            end
        end

        check("R11 drive onset while scl high", onset_viol, 0);
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule